// File: doc/BRIEF.md
# Fractional Rate-Matching Tick Generator

This block derives two clock-enable strobes from one master clock. The first is an output sample strobe that fires once every 768 enabled master clocks. The second is an engine tick strobe. It paces a synthesis engine whose native rate is the master clock divided by 684, which is slightly faster than the sample rate. The two rates stand in the exact ratio 192:171. No integer divider can produce that ratio, so the block issues one engine tick with every sample strobe. It also keeps a small fractional accumulator that adds 21 per sample against a modulus of 171. Whenever that accumulator wraps, one extra engine tick is inserted partway through the following sample period.

Over any run of 171 sample periods the engine therefore receives exactly 192 ticks, with no long-term drift. The extra tick is always placed a fixed number of clocks after the sample strobe that caused it, so the two strobes never share a cycle. A running tick count is provided for downstream sequencing. A synchronous enable freezes all timing state in place without losing it.

Top module: `frac_tick_gen`

## Requirements
- R1: After reset, `sample_stb` first goes high 768 enabled clocks after reset is released. It then repeats every 768 enabled clocks, and each pulse lasts exactly one cycle.
- R2: Every cycle in which `sample_stb` is high also has `tick_stb` high.
- R3: Each sample strobe adds 21 to an accumulator that starts at 0. When the sum is 171 or more, 171 is subtracted and an extra tick is owed. Starting from reset, samples 1 to 8 therefore owe no extra tick, and sample 9 is the first that does.
- R4: An owed extra tick appears on `tick_stb` exactly 384 enabled clocks after the sample strobe that caused it. At most one extra tick occurs in any sample period, and it never coincides with a sample strobe.
- R5: Across the windows of 171 consecutive sample strobes starting from reset, exactly 192 engine ticks occur. Each window counts every tick from its first sample strobe up to, but not including, the next strobe after the window.
- R6: `tick_count` increases by one, modulo 2^16, in exactly the cycle in which `tick_stb` is high, and holds otherwise.
- R7: While `en` is low, the period counter, the accumulator and any owed extra tick are held unchanged, and neither strobe fires. When `en` returns high, timing resumes where it stopped.
- R8: While `rst` is high, `sample_stb`, `tick_stb` and `tick_count` are all 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Master clock |
| rst | input | 1 | Synchronous active-high reset |
| en | input | 1 | Clock enable; low freezes all timing state |
| sample_stb | output | 1 | One-cycle output sample strobe |
| tick_stb | output | 1 | One-cycle engine tick strobe |
| tick_count | output | 16 | Running count of engine ticks, wraps |

## Verification
On every cycle, the assertions check the local relationships:
- a sample strobe carries a tick and lasts one cycle;
- the accumulator stays below its modulus;
- an owed tick only arises at a sample boundary;
- the tick count steps exactly with the tick strobe;
- a low enable freezes the counters and suppresses both strobes.

Only the bench scenarios can show properties that span many periods. These are the exact 768-clock spacing, the absence of any extra tick for samples 1 to 8, the 384-clock placement of the first extra tick, and the 192-per-171 total. The same holds for the resumed timing after an enable gap, including a gap that falls between an owed tick and its slot.

// File: rtl/frac_tick_pkg.sv
package frac_tick_pkg;
  // Default rate relationship: sample period, accumulator step and modulus
  localparam int unsigned DEF_SAMPLE_DIV = 768;
  localparam int unsigned DEF_FRAC_STEP  = 21;
  localparam int unsigned DEF_FRAC_MOD   = 171;
  localparam int unsigned DEF_EXTRA_GAP  = 384;
  localparam int unsigned DEF_ACC_W      = 8;
  localparam int unsigned DEF_TCOUNT_W   = 16;

  typedef struct packed {
    logic boundary;    // last enabled clock of a sample period
    logic extra_slot;  // enabled clock where an owed tick may be issued
  } slot_evt_t;
endpackage

// File: rtl/ftg_period_counter.sv
module ftg_period_counter
  import frac_tick_pkg::*;
#(
  parameter int unsigned SAMPLE_DIV = DEF_SAMPLE_DIV,
  parameter int unsigned EXTRA_GAP  = DEF_EXTRA_GAP,
  localparam int unsigned CNT_W     = $clog2(SAMPLE_DIV)
) (
  input  logic             clk,
  input  logic             rst,
  input  logic             en,
  output logic [CNT_W-1:0] phase,
  output slot_evt_t        evt
);
  localparam logic [CNT_W-1:0] LAST_PH  = CNT_W'(SAMPLE_DIV - 1);
  localparam logic [CNT_W-1:0] EXTRA_PH = CNT_W'(EXTRA_GAP - 1);

  always_ff @(posedge clk) begin
    if (rst) begin
      phase <= '0;
    end else if (en) begin
      if (phase == LAST_PH) phase <= '0;
      else                  phase <= phase + 1'b1;
    end
  end

  always_comb begin
    evt.boundary   = en && (phase == LAST_PH);
    evt.extra_slot = en && (phase == EXTRA_PH);
  end

  AST_PHASE_IN_RANGE: assert property (@(posedge clk) disable iff (rst)
    phase <= LAST_PH); // R1
  AST_PHASE_FROZEN: assert property (@(posedge clk) disable iff (rst)
    !en |=> $stable(phase)); // R7
endmodule

// File: rtl/ftg_frac_accum.sv
module ftg_frac_accum
  import frac_tick_pkg::*;
#(
  parameter int unsigned FRAC_STEP = DEF_FRAC_STEP,
  parameter int unsigned FRAC_MOD  = DEF_FRAC_MOD,
  parameter int unsigned ACC_W     = DEF_ACC_W,
  localparam int unsigned SUM_W    = ACC_W + 1
) (
  input  logic             clk,
  input  logic             rst,
  input  logic             boundary,
  input  logic             take,
  output logic [ACC_W-1:0] acc,
  output logic             owed
);
  logic [SUM_W-1:0] sum;
  logic             wrap;

  always_comb begin
    sum  = {1'b0, acc} + SUM_W'(FRAC_STEP);
    wrap = (sum >= SUM_W'(FRAC_MOD));
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      acc  <= '0;
      owed <= 1'b0;
    end else if (boundary) begin
      acc  <= wrap ? ACC_W'(sum - SUM_W'(FRAC_MOD)) : ACC_W'(sum);
      owed <= wrap;
    end else if (take) begin
      owed <= 1'b0;
    end
  end

  AST_ACC_BELOW_MOD: assert property (@(posedge clk) disable iff (rst)
    acc < ACC_W'(FRAC_MOD)); // R3
  AST_OWED_FROM_BOUNDARY: assert property (@(posedge clk) disable iff (rst)
    $rose(owed) |-> $past(boundary)); // R4
endmodule

// File: rtl/ftg_strobe_out.sv
module ftg_strobe_out
  import frac_tick_pkg::*;
#(
  parameter int unsigned TCOUNT_W = DEF_TCOUNT_W
) (
  input  logic                clk,
  input  logic                rst,
  input  logic                boundary,
  input  logic                take,
  output logic                sample_stb,
  output logic                tick_stb,
  output logic [TCOUNT_W-1:0] tick_count
);
  logic tick_next;
  assign tick_next = boundary | take;

  always_ff @(posedge clk) begin
    if (rst) begin
      sample_stb <= 1'b0;
      tick_stb   <= 1'b0;
      tick_count <= '0;
    end else begin
      sample_stb <= boundary;
      tick_stb   <= tick_next;
      if (tick_next) tick_count <= tick_count + 1'b1;
    end
  end

  AST_COUNT_STEPS: assert property (@(posedge clk) disable iff (rst)
    tick_stb |-> tick_count == $past(tick_count) + 1'b1); // R6
  AST_COUNT_HOLDS: assert property (@(posedge clk) disable iff (rst)
    !tick_stb |-> $stable(tick_count)); // R6
endmodule

// File: rtl/frac_tick_gen.sv
module frac_tick_gen
  import frac_tick_pkg::*;
#(
  parameter int unsigned SAMPLE_DIV = DEF_SAMPLE_DIV,
  parameter int unsigned FRAC_STEP  = DEF_FRAC_STEP,
  parameter int unsigned FRAC_MOD   = DEF_FRAC_MOD,
  parameter int unsigned EXTRA_GAP  = DEF_EXTRA_GAP,
  parameter int unsigned ACC_W      = DEF_ACC_W,
  parameter int unsigned TCOUNT_W   = DEF_TCOUNT_W,
  localparam int unsigned CNT_W     = $clog2(SAMPLE_DIV)
) (
  input  logic                clk,
  input  logic                rst,
  input  logic                en,
  output logic                sample_stb,
  output logic                tick_stb,
  output logic [TCOUNT_W-1:0] tick_count
);
  logic [CNT_W-1:0] phase;
  slot_evt_t        evt;
  logic [ACC_W-1:0] acc;
  logic             owed;
  logic             take;

  ftg_period_counter #(
    .SAMPLE_DIV(SAMPLE_DIV),
    .EXTRA_GAP (EXTRA_GAP)
  ) u_period (
    .clk  (clk),
    .rst  (rst),
    .en   (en),
    .phase(phase),
    .evt  (evt)
  );

  assign take = evt.extra_slot & owed;

  ftg_frac_accum #(
    .FRAC_STEP(FRAC_STEP),
    .FRAC_MOD (FRAC_MOD),
    .ACC_W    (ACC_W)
  ) u_accum (
    .clk     (clk),
    .rst     (rst),
    .boundary(evt.boundary),
    .take    (take),
    .acc     (acc),
    .owed    (owed)
  );

  ftg_strobe_out #(
    .TCOUNT_W(TCOUNT_W)
  ) u_out (
    .clk       (clk),
    .rst       (rst),
    .boundary  (evt.boundary),
    .take      (take),
    .sample_stb(sample_stb),
    .tick_stb  (tick_stb),
    .tick_count(tick_count)
  );

  AST_SAMPLE_HAS_TICK: assert property (@(posedge clk) disable iff (rst)
    sample_stb |-> tick_stb); // R2
  AST_SAMPLE_ONE_CYCLE: assert property (@(posedge clk) disable iff (rst)
    sample_stb |=> !sample_stb); // R1
  AST_STATE_FROZEN: assert property (@(posedge clk) disable iff (rst)
    !en |=> $stable(acc) && $stable(owed)); // R7
  AST_QUIET_WHEN_OFF: assert property (@(posedge clk) disable iff (rst)
    !en |=> !sample_stb && !tick_stb); // R7
endmodule

// File: tb/frac_tick_gen_bench.sv
module frac_tick_gen_bench;
  localparam int WD_LIMIT = 190000;

  logic        clk = 1'b0;
  logic        rst = 1'b1;
  logic        en  = 1'b0;
  logic        sample_stb;
  logic        tick_stb;
  logic [15:0] tick_count;

  int n_checks = 0;
  int n_fail   = 0;
  int cycles   = 0;

  always #4 clk = ~clk;  // 125 MHz

  frac_tick_gen u_frac_tick_gen (
    .clk(clk), .rst(rst), .en(en),
    .sample_stb(sample_stb), .tick_stb(tick_stb), .tick_count(tick_count)
  );

  task automatic finish_run();
    $display("%0d/%0d checks passed", n_checks - n_fail, n_checks);
    $finish;
  endtask

  task automatic chk(input bit ok, input string req, input longint act, input longint exp);
    n_checks++;
    if (!ok) begin
      n_fail++;
      $display("FAIL %s: actual %0d expected %0d", req, act, exp);
    end
  endtask

  task automatic step();
    @(negedge clk);
    cycles++;
    if (cycles > WD_LIMIT) begin
      chk(1'b0, "watchdog", cycles, WD_LIMIT);
      finish_run();
    end
  endtask

  task automatic do_reset();
    rst = 1'b1; en = 1'b0;
    repeat (3) step();
    rst = 1'b0; en = 1'b1;
  endtask

  // Steps through one sample period; returns its length, the extra ticks and the last extra position
  task automatic run_period(output int len, output int extras, output int pos, output bit overlap);
    len = 0; extras = 0; pos = -1; overlap = 0;
    forever begin
      step();
      len++;
      if (sample_stb) begin
        if (!tick_stb) overlap = 1;
        break;
      end
      if (tick_stb) begin extras++; pos = len; end
    end
  endtask

  task automatic t_reset();
    rst = 1'b1; en = 1'b1;
    repeat (4) step();
    chk(sample_stb == 0 && tick_stb == 0, "R8 strobes in reset", {sample_stb, tick_stb}, 0);
    chk(tick_count == 0, "R8 tick_count in reset", tick_count, 0);
    rst = 1'b0;
  endtask

  task automatic t_period();
    int len, ex, pos; bit ov;
    do_reset();
    run_period(len, ex, pos, ov);
    chk(len == 768, "R1 first sample delay", len, 768);
    chk(!ov, "R2 tick with sample", ov, 0);
    chk(tick_count == 1, "R6 count after first tick", tick_count, 1);
    step();
    chk(sample_stb == 0, "R1 one-cycle pulse", sample_stb, 0);
    chk(tick_count == 1, "R6 count holds", tick_count, 1);
    run_period(len, ex, pos, ov);
    chk(len == 767, "R1 period spacing", len + 1, 768);
  endtask

  task automatic t_extra();
    int len, ex, pos; bit ov;
    do_reset();
    run_period(len, ex, pos, ov);  // sample 1 strobe
    for (int k = 1; k <= 8; k++) begin
      run_period(len, ex, pos, ov);
      chk(ex == 0, $sformatf("R3 no extra after sample %0d", k), ex, 0);
    end
    run_period(len, ex, pos, ov);  // period after sample 9
    chk(ex == 1, "R3 extra after sample 9", ex, 1);
    chk(pos == 384, "R4 extra position", pos, 384);
    chk(len == 768 && !ov, "R4 period intact", len, 768);
    run_period(len, ex, pos, ov);
    chk(ex == 0, "R3 no extra after sample 10", ex, 0);
  endtask

  task automatic t_total();
    int len, ex, pos; bit ov;
    int ticks, max_ex, bad_len;
    do_reset();
    run_period(len, ex, pos, ov);  // sample 1
    ticks = 1; max_ex = 0; bad_len = 0;
    for (int k = 1; k <= 171; k++) begin
      run_period(len, ex, pos, ov);
      ticks += ex;
      if (k < 171) ticks++;        // strobe of samples 2..171
      if (ex > max_ex) max_ex = ex;
      if (len != 768 || ov) bad_len++;
    end
    chk(ticks == 192, "R5 ticks per 171 samples", ticks, 192);
    chk(max_ex == 1, "R4 at most one extra per period", max_ex, 1);
    chk(bad_len == 0, "R1 spacing over long run", bad_len, 0);
    chk(tick_count == 193, "R6 running count", tick_count, 193);
  endtask

  task automatic t_enable();
    int len, ex, pos; bit ov; int quiet;
    do_reset();
    repeat (100) step();
    en = 1'b0; quiet = 0;
    repeat (50) begin step(); if (sample_stb || tick_stb) quiet++; end
    en = 1'b1;
    chk(quiet == 0, "R7 no strobes while off", quiet, 0);
    run_period(len, ex, pos, ov);
    chk(len == 668, "R7 first sample resumes", len, 668);
    for (int k = 2; k <= 9; k++) run_period(len, ex, pos, ov);
    // period after sample 9: freeze between owed tick and its slot
    repeat (200) begin step(); if (tick_stb) quiet++; end
    en = 1'b0;
    repeat (37) begin step(); if (sample_stb || tick_stb) quiet++; end
    en = 1'b1;
    chk(quiet == 0, "R7 owed tick held while off", quiet, 0);
    run_period(len, ex, pos, ov);
    chk(ex == 1 && pos == 184, "R7 owed tick after resume", pos, 184);
    chk(len == 568, "R7 period resumes", len, 568);
  endtask

  initial begin
    t_reset();
    t_period();
    t_extra();
    t_total();
    t_enable();
    finish_run();
  end
endmodule